// File: doc/BRIEF.md
# Grouped Pin-Change Interrupt Controller

This block watches 23 general-purpose input pins, arranged as three groups of 8, 7 and 8 pins. Any level change on a pin, rising or falling, counts as an event. An event sets its group's sticky flag when the pin's own mask bit and the group's enable bit are both 1. Each group drives its own interrupt request line. The line is high while that group's flag, the group's enable bit and a global interrupt enable input are all 1.

A group's flag is cleared in two ways. The interrupt vectoring logic can pulse that group's acknowledge input, or software can write a 1 to the flag bit. A byte-wide register port gives access to the three mask registers, the group-enable register and the flag register. Each pin is brought into the clock domain through a two-flop synchronizer. A change is found by comparing the synchronized level with the level registered one cycle earlier.

Top module: `pcx_ctrl`

## Requirements
- R1: After reset, the three mask registers, the group-enable register and the flag register all read 0, and `irq_o` is 0.
- R2: A rising or a falling level on a qualifying pin, applied before clock edge k, sets the group's flag at edge k+2. The flag is not yet set after edge k+1.
- R3: A change on a pin whose mask bit is 0 leaves its flag unchanged. A change in a group whose enable bit is 0 also leaves its flag unchanged.
- R4: Once set, a flag stays set until a clear. Clearing the group enable does not clear the flag.
- R5: A 1 on `ack_i[g]` during a clock edge clears flag g at that edge.
- R6: The flag register is at address 0x69, with bit g holding group g's flag. Writing 1 to bit g clears flag g. Writing 0 to bit g leaves flag g unchanged.
- R7: If a qualifying change and a clear (by acknowledge or by write-one) reach the same edge, the flag ends that edge set.
- R8: `irq_o[g]` is 1 exactly when flag g, enable bit g and `glob_ie_i` are all 1.
- R9: Bit 7 of the group-1 mask register always reads 0 and cannot be set. Bits 7..3 of the enable and flag registers read 0.
- R10: The mask registers for groups 0, 1 and 2 are at 0x6B, 0x6C and 0x6D. The group-enable register is at 0x68, with bit g enabling group g. Pins map as group 0 = `pins_i[7:0]`, group 1 = `pins_i[14:8]` and group 2 = `pins_i[22:15]`, with mask bit i guarding the group's i-th pin. A read returns data in the same cycle as the address, and a write takes effect at the next edge. Any other address reads 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| pins_i | input | 23 | Asynchronous pin levels, grouped as in R10 |
| glob_ie_i | input | 1 | Global interrupt enable |
| ack_i | input | 3 | Per-group service acknowledge pulse |
| reg_wr_i | input | 1 | Register write strobe |
| reg_addr_i | input | 8 | Register address |
| reg_wdata_i | input | 8 | Register write data |
| reg_rdata_o | output | 8 | Register read data (combinational) |
| irq_o | output | 3 | Per-group interrupt request |

## Verification
The hardest case to reach from the ports is a new qualifying pin change landing on the same edge as a flag clear. The clear arrives two edges after the pin moves, because of the synchronizer and the change register. Directed tests toggle a pin, wait exactly two edges, and then apply either the acknowledge or a write-one on the edge where the change arrives. Random stimulus also produces many such collisions. It uses frequent pin toggles, random acknowledges and random flag writes, and every cycle is compared against a bench model of the pipeline.

// File: rtl/pcx_pkg.sv
package pcx_pkg;
  localparam int NGRP = 3;
  localparam int RW   = 8;
  typedef logic [RW-1:0] rbyte_t;
endpackage

// File: rtl/pcx_sync.sv
module pcx_sync #(
  parameter int N = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] din,
  output logic [N-1:0] chg
);
  logic [N-1:0] meta_q, sync_q, prev_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      meta_q <= '0;
      sync_q <= '0;
      prev_q <= '0;
    end else begin
      meta_q <= din;
      sync_q <= meta_q;
      prev_q <= sync_q;
    end
  end

  assign chg = sync_q ^ prev_q;
endmodule

// File: rtl/pcx_group.sv
module pcx_group
  import pcx_pkg::*;
#(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] chg,
  input  logic         grp_en,
  input  logic         mask_we,
  input  rbyte_t       wdata,
  input  logic         clr_w1,
  input  logic         ack,
  output rbyte_t       mask_q,
  output logic         flag
);
  logic [W-1:0] mask_r;
  logic         set, clr;

  assign set = grp_en & (|(chg & mask_r));
  assign clr = ack | clr_w1;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mask_r <= '0;
      flag   <= 1'b0;
    end else begin
      if (mask_we) mask_r <= wdata[W-1:0];
      flag <= (flag & ~clr) | set;
    end
  end

  always_comb begin
    mask_q = '0;
    mask_q[W-1:0] = mask_r;
  end

  // R4: a set flag holds while no clear is present
  p_sticky_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (flag && !clr) |=> flag);
  // R7: a qualifying change wins over any clear
  p_set_wins_r7: assert property (@(posedge clk) disable iff (!rst_n)
    set |=> flag);
  // R5: acknowledge without a new change empties the flag
  p_ack_clears_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (ack && !set) |=> !flag);
  // R3: without a qualified change the flag cannot rise
  p_no_spurious_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (!flag && !set) |=> !flag);
endmodule

// File: rtl/pcx_ctrl.sv
module pcx_ctrl
  import pcx_pkg::*;
#(
  parameter int         W0   = 8,
  parameter int         W1   = 7,
  parameter int         W2   = 8,
  parameter logic [7:0] A_M0 = 8'h6B,
  parameter logic [7:0] A_EN = 8'h68,
  parameter logic [7:0] A_FL = 8'h69,
  localparam int        NPIN = W0 + W1 + W2
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [NPIN-1:0] pins_i,
  input  logic            glob_ie_i,
  input  logic [2:0]      ack_i,
  input  logic            reg_wr_i,
  input  logic [7:0]      reg_addr_i,
  input  logic [7:0]      reg_wdata_i,
  output logic [7:0]      reg_rdata_o,
  output logic [2:0]      irq_o
);
  logic [NPIN-1:0] chg;
  logic [NGRP-1:0] en_q, flag;
  rbyte_t          mask_q [NGRP];
  logic            fl_we;

  pcx_sync #(.N(NPIN)) u_sync (
    .clk(clk), .rst_n(rst_n), .din(pins_i), .chg(chg)
  );

  assign fl_we = reg_wr_i && (reg_addr_i == A_FL);

  for (genvar g = 0; g < NGRP; g++) begin : g_grp
    localparam int W   = (g == 0) ? W0 : (g == 1) ? W1 : W2;
    localparam int OFF = (g == 0) ? 0  : (g == 1) ? W0 : W0 + W1;
    localparam logic [7:0] AM = A_M0 + 8'(g);
    pcx_group #(.W(W)) u_grp (
      .clk    (clk),
      .rst_n  (rst_n),
      .chg    (chg[OFF +: W]),
      .grp_en (en_q[g]),
      .mask_we(reg_wr_i && (reg_addr_i == AM)),
      .wdata  (reg_wdata_i),
      .clr_w1 (fl_we && reg_wdata_i[g]),
      .ack    (ack_i[g]),
      .mask_q (mask_q[g]),
      .flag   (flag[g])
    );
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                              en_q <= '0;
    else if (reg_wr_i && reg_addr_i == A_EN) en_q <= reg_wdata_i[NGRP-1:0];
  end

  assign irq_o = flag & en_q & {NGRP{glob_ie_i}};

  always_comb begin
    reg_rdata_o = '0;
    if (reg_addr_i == A_EN)            reg_rdata_o[NGRP-1:0] = en_q;
    else if (reg_addr_i == A_FL)       reg_rdata_o[NGRP-1:0] = flag;
    else if (reg_addr_i == A_M0)       reg_rdata_o = mask_q[0];
    else if (reg_addr_i == A_M0 + 8'd1) reg_rdata_o = mask_q[1];
    else if (reg_addr_i == A_M0 + 8'd2) reg_rdata_o = mask_q[2];
  end

  // R10: a write to the enable register shows at the next edge
  p_en_write_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_wr_i && reg_addr_i == A_EN) |=> (en_q == $past(reg_wdata_i[NGRP-1:0])));
  // R6: a write of zeros to the flag register cannot clear a flag
  p_w0_keeps_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (fl_we && reg_wdata_i == 8'h00 && ack_i == 3'b000) |=> (($past(flag) & ~flag) == 3'b000));
endmodule

// File: tb/pcx_ctrl_tb_top.sv
module pcx_ctrl_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [22:0] pins = '0;
  logic        gie = 1'b0;
  logic [2:0]  ack = '0;
  logic        wr = 1'b0;
  logic [7:0]  addr = '0;
  logic [7:0]  wdata = '0;
  logic [7:0]  rdata;
  logic [2:0]  irq;

  int checks = 0;
  int errors = 0;

  // bench model
  logic [22:0] m1 = '0, m2 = '0, m3 = '0;
  logic [7:0]  mm0 = '0, mm1 = '0, mm2 = '0;
  logic [2:0]  men = '0, mfl = '0;

  always #4 clk = ~clk;

  pcx_ctrl dut_i (
    .clk(clk), .rst_n(rst_n), .pins_i(pins), .glob_ie_i(gie), .ack_i(ack),
    .reg_wr_i(wr), .reg_addr_i(addr), .reg_wdata_i(wdata),
    .reg_rdata_o(rdata), .irq_o(irq)
  );

  function automatic logic [7:0] exp_rd(input logic [7:0] a);
    case (a)
      8'h6B:   return mm0;
      8'h6C:   return mm1;
      8'h6D:   return mm2;
      8'h68:   return {5'b0, men};
      8'h69:   return {5'b0, mfl};
      default: return 8'h00;
    endcase
  endfunction

  function automatic logic [2:0] exp_irq();
    return mfl & men & {3{gie}};
  endfunction

  task automatic model_edge();
    logic [22:0] c;
    logic [2:0]  s, k;
    c = m2 ^ m3;
    s[0] = men[0] & (|(c[7:0]   & mm0));
    s[1] = men[1] & (|(c[14:8]  & mm1[6:0]));
    s[2] = men[2] & (|(c[22:15] & mm2));
    k = ack | ((wr && addr == 8'h69) ? wdata[2:0] : 3'b000);
    mfl = (mfl & ~k) | s;
    if (wr && addr == 8'h6B) mm0 = wdata;
    if (wr && addr == 8'h6C) mm1 = {1'b0, wdata[6:0]};
    if (wr && addr == 8'h6D) mm2 = wdata;
    if (wr && addr == 8'h68) men = wdata[2:0];
    m3 = m2; m2 = m1; m1 = pins;
  endtask

  task automatic step(input int n = 1);
    for (int i = 0; i < n; i++) begin
      @(posedge clk);
      if (rst_n) model_edge();
      @(negedge clk);
    end
  endtask

  task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %02h expected %02h", tag, act, exp);
    end
  endtask

  task automatic rd(input string tag, input logic [7:0] a, input logic [7:0] exp);
    addr = a;
    #1;
    chk(tag, rdata, exp);
  endtask

  task automatic wreg(input logic [7:0] a, input logic [7:0] d);
    addr = a; wdata = d; wr = 1'b1;
    step();
    wr = 1'b0;
  endtask

  initial begin
    #1_000_000;
    errors++;
    $display("FAIL watchdog: actual hung expected done");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    rd("R1 mask0", 8'h6B, 8'h00);
    rd("R1 mask1", 8'h6C, 8'h00);
    rd("R1 mask2", 8'h6D, 8'h00);
    rd("R1 enable", 8'h68, 8'h00);
    rd("R1 flags", 8'h69, 8'h00);
    chk("R1 irq", {5'b0, irq}, 8'h00);
    // R9 reserved mask bit
    wreg(8'h6C, 8'hFF);
    rd("R9 mask1 bit7", 8'h6C, 8'h7F);
    wreg(8'h6B, 8'h01);
    wreg(8'h68, 8'h07);
    gie = 1'b1;
    // R2 rising edge timing
    pins[0] = 1'b1;
    step(2);
    rd("R2 not yet", 8'h69, 8'h00);
    step();
    rd("R2 rise sets", 8'h69, 8'h01);
    chk("R8 irq on", {5'b0, irq}, 8'h01);
    // R6 write zero / write one
    wreg(8'h69, 8'h00);
    rd("R6 write0 keeps", 8'h69, 8'h01);
    wreg(8'h69, 8'h01);
    rd("R6 write1 clears", 8'h69, 8'h00);
    // R2 falling, R5 ack
    pins[0] = 1'b0;
    step(3);
    rd("R2 fall sets", 8'h69, 8'h01);
    ack = 3'b001; step(); ack = 3'b000;
    rd("R5 ack clears", 8'h69, 8'h00);
    // R3 masked pin
    pins[1] = 1'b1;
    step(4);
    rd("R3 masked ignored", 8'h69, 8'h00);
    // R3 group disabled
    wreg(8'h68, 8'h06);
    pins[0] = 1'b1;
    step(4);
    rd("R3 group off ignored", 8'h69, 8'h00);
    wreg(8'h68, 8'h07);
    step(2);
    rd("R3 no late set", 8'h69, 8'h00);
    // R8 gating, R4 sticky
    pins[0] = 1'b0;
    step(3);
    gie = 1'b0; #1;
    chk("R8 gie off", {5'b0, irq}, 8'h00);
    gie = 1'b1; #1;
    chk("R8 gie on", {5'b0, irq}, 8'h01);
    wreg(8'h68, 8'h06);
    chk("R8 en off", {5'b0, irq}, 8'h00);
    rd("R4 flag kept", 8'h69, 8'h01);
    wreg(8'h68, 8'h07);
    // R7 set wins over ack
    pins[0] = 1'b1;
    step(2);
    ack = 3'b001; step(); ack = 3'b000;
    rd("R7 set beats ack", 8'h69, 8'h01);
    // R7 set wins over write-one
    pins[0] = 1'b0;
    step(2);
    wreg(8'h69, 8'h01);
    rd("R7 set beats w1c", 8'h69, 8'h01);
    wreg(8'h69, 8'h07);
    rd("R6 cleared", 8'h69, 8'h00);
    // R10 mapping of groups 1 and 2
    wreg(8'h6D, 8'h80);
    pins[22] = 1'b1;
    step(3);
    rd("R10 group2 pin", 8'h69, 8'h04);
    pins[14] = 1'b1;
    step(3);
    rd("R10 group1 pin", 8'h69, 8'h06);
    chk("R8 irq two", {5'b0, irq}, 8'h06);
    wreg(8'h69, 8'h07);
    // R9 unused bits, R10 unknown address
    wreg(8'h68, 8'hFF);
    rd("R9 enable upper", 8'h68, 8'h07);
    rd("R10 unmapped", 8'h70, 8'h00);

    // random phase
    begin
      int seed_dummy;
      seed_dummy = $urandom(32'd1234);
    end
    for (int it = 0; it < 4000; it++) begin
      logic [7:0] sel;
      chk("R8 random irq", {5'b0, irq}, {5'b0, exp_irq()});
      chk("R10 random read", rdata, exp_rd(addr));
      for (int b = 0; b < 23; b++)
        if ($urandom_range(0, 15) == 0) pins[b] = ~pins[b];
      gie = ($urandom_range(0, 7) != 0);
      ack = ($urandom_range(0, 5) == 0) ? 3'($urandom) : 3'b000;
      sel = 8'($urandom_range(0, 6));
      addr = (sel < 3) ? 8'h6B + sel : (sel == 3) ? 8'h68 : (sel == 4) ? 8'h69 : 8'h42;
      wr = ($urandom_range(0, 5) == 0);
      wdata = 8'($urandom);
      if (wr && addr == 8'h69 && $urandom_range(0, 1) == 0) wdata = 8'h00;
      step();
      wr = 1'b0;
      ack = 3'b000;
    end
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule